// File: doc/BRIEF.md
# End-Around-Carry Prefix Adder Modulo 2^W-1

This block adds two residues modulo 2^W-1 and returns their sum in the same residue class. The operands are W-bit words. The carry network is a logarithmic-depth parallel-prefix tree with Kogge-Stone spacing, not a ripple chain.

The carry that leaves the top bit is fed back as the carry into bit 0 without a second addition pass. The group generate and group propagate of the whole word are combined into one recirculated carry. That carry is then merged into every bit position through the prefix terms that the tree has already computed.

Modulo 2^W-1, the all-zeros word and the all-ones word both stand for zero. The adder folds both to all-zeros, so a result word of all ones never appears. An operand equal to all ones is accepted and acts as zero. A parameter selects whether the result leaves through an output register or straight from the logic. The intended use is as a modular stage inside larger residue-arithmetic datapaths, such as reverse converters. It is meant for word sizes of 4, 8, 12 and 16 bits.

Top module: `eac_prefix_adder`

## Requirements
- R1: For every operand pair A, B, `sum` equals (A + B) mod (2^W-1), for W in {4, 8, 12, 16}.
- R2: `sum` never takes the all-ones value; every result lies in 0 .. 2^W-2.
- R3: When the operands are bitwise complements (A + B = 2^W-1) and neither is all ones, `sum` is all zeros.
- R4: An all-ones operand acts as zero: `sum` equals the other operand, reduced (all ones becomes zero). Two all-ones operands give all zeros.
- R5: When A + B is 2^W or more, the carry out of bit W-1 is added back at bit 0, so `sum` equals A + B - 2^W + 1.
- R6: With REGISTERED = 1, `sum` reflects the operands present at the previous rising clock edge and does not change between edges. With REGISTERED = 0, `sum` follows the operands with no clock involved.
- R7: With REGISTERED = 1, `sum` is all zeros while `rst_n` is low (asynchronous, active-low reset).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| op_a | input | W | First residue operand |
| op_b | input | W | Second residue operand |
| sum | output | W | Residue sum modulo 2^W-1, never all ones |

## Verification
The bench builds four copies side by side, one for each supported width: W = 4 without the register, and W = 8, 12 and 16 with it. Driving them together puts both the combinational path and the registered latency under the same checks. The 16-bit input walk covers every operand pair exhaustively at W = 4 and W = 8, so every complement pair, every all-ones case and every carry-wrap case at those widths is reached. At W = 12 and W = 16, directed corner pairs and random pairs exercise the deepest prefix trees.

// File: rtl/eac_adder_pkg.sv
`timescale 1ns/1ps
package eac_adder_pkg;

    // generate / propagate pair carried through the prefix tree
    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    // prefix combine: hi covers the upper span, lo the span just below it
    function automatic gp_t gp_merge(input gp_t hi, input gp_t lo);
        gp_t r;
        r.g = hi.g | (hi.p & lo.g);
        r.p = hi.p & lo.p;
        return r;
    endfunction

    function automatic int tree_levels(input int width);
        return (width < 2) ? 1 : $clog2(width);
    endfunction

endpackage

// File: rtl/eac_pg_stage.sv
`timescale 1ns/1ps
module eac_pg_stage
    import eac_adder_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output gp_t  [W-1:0] gp_bit,
    output logic [W-1:0] half_sum,
    output logic         both_ones
);

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            assign gp_bit[i].g = a[i] & b[i];
            assign gp_bit[i].p = a[i] ^ b[i];
            assign half_sum[i] = a[i] ^ b[i];
        end
    endgenerate

    // both operands are the redundant zero: every bit generates
    assign both_ones = &(a & b);

endmodule

// File: rtl/eac_prefix_tree.sv
`timescale 1ns/1ps
module eac_prefix_tree
    import eac_adder_pkg::*;
#(
    parameter int W = 8
) (
    input  gp_t [W-1:0] gp_bit,
    output gp_t [W-1:0] grp      // grp[i] spans bits i down to 0
);

    localparam int LV = tree_levels(W);

    gp_t [W-1:0] lvl [LV+1];

    assign lvl[0] = gp_bit;

    genvar l, i;
    generate
        for (l = 0; l < LV; l++) begin : g_lvl
            localparam int SPAN = 1 << l;
            for (i = 0; i < W; i++) begin : g_node
                if (i >= SPAN) begin : g_black
                    assign lvl[l+1][i] = gp_merge(lvl[l][i], lvl[l][i-SPAN]);
                end else begin : g_pass
                    assign lvl[l+1][i] = lvl[l][i];
                end
            end
        end
    endgenerate

    assign grp = lvl[LV];

endmodule

// File: rtl/eac_sum_stage.sv
`timescale 1ns/1ps
module eac_sum_stage
    import eac_adder_pkg::*;
#(
    parameter int W = 8
) (
    input  gp_t  [W-1:0] grp,
    input  logic [W-1:0] half_sum,
    input  logic         both_ones,
    output logic [W-1:0] res
);

    logic          wrap_c;
    logic [W-1:0]  carry;

    // recirculated carry: a real carry out, or the all-propagate word,
    // which is forced to wrap so that A+B = 2^W-1 lands on zero
    assign wrap_c   = grp[W-1].g | grp[W-1].p;
    assign carry[0] = wrap_c;

    genvar i;
    generate
        for (i = 1; i < W; i++) begin : g_c
            assign carry[i] = grp[i-1].g | (grp[i-1].p & wrap_c);
        end
    endgenerate

    // double-zero guard masks the only pair that would yield all ones
    assign res = (half_sum ^ carry) & {W{~both_ones}};

endmodule

// File: rtl/eac_prefix_adder.sv
`timescale 1ns/1ps
module eac_prefix_adder
    import eac_adder_pkg::*;
#(
    parameter int W          = 8,
    parameter bit REGISTERED = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] sum
);

    gp_t  [W-1:0] gp_bit;
    gp_t  [W-1:0] grp;
    logic [W-1:0] half_sum;
    logic         both_ones;
    logic [W-1:0] comb_sum;

    eac_pg_stage #(.W(W)) u_pg (
        .a         (op_a),
        .b         (op_b),
        .gp_bit    (gp_bit),
        .half_sum  (half_sum),
        .both_ones (both_ones)
    );

    eac_prefix_tree #(.W(W)) u_tree (
        .gp_bit (gp_bit),
        .grp    (grp)
    );

    eac_sum_stage #(.W(W)) u_sum (
        .grp       (grp),
        .half_sum  (half_sum),
        .both_ones (both_ones),
        .res       (comb_sum)
    );

    generate
        if (REGISTERED) begin : g_reg
            typedef struct packed {
                logic [W-1:0] sum;
            } state_t;

            state_t state_d, state_q;

            always_comb begin
                state_d     = state_q;
                state_d.sum = comb_sum;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) state_q <= '0;
                else        state_q <= state_d;
            end

            assign sum = state_q.sum;
        end else begin : g_comb
            assign sum = comb_sum;
        end
    endgenerate

endmodule

// File: rtl/eac_prefix_adder_chk.sv
`timescale 1ns/1ps
module eac_prefix_adder_chk #(
    parameter int W          = 8,
    parameter bit REGISTERED = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic [W-1:0] sum
);

    localparam logic [W-1:0] ONES = '1;

    function automatic logic [W-1:0] mod_ref(input logic [W-1:0] x, input logic [W-1:0] y);
        int m;
        m = (1 << W) - 1;
        return W'(((int'(x) % m) + (int'(y) % m)) % m);
    endfunction

    logic         seen_q;
    logic [W-1:0] a_q, b_q;
    logic [W-1:0] obs_a, obs_b;
    logic         armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            a_q    <= '0;
            b_q    <= '0;
        end else begin
            seen_q <= 1'b1;
            a_q    <= op_a;
            b_q    <= op_b;
        end
    end

    assign obs_a = REGISTERED ? a_q : op_a;
    assign obs_b = REGISTERED ? b_q : op_b;
    assign armed = REGISTERED ? seen_q : 1'b1;

    AST_SUM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (sum == mod_ref(obs_a, obs_b))); // R1

    AST_NO_ALLONES: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (sum != ONES)); // R2

    AST_COMPLEMENT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && ((obs_a ^ obs_b) == ONES)) |-> (sum == '0)); // R3

    AST_ONES_NEUTRAL: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && (obs_a == ONES)) |-> (sum == ((obs_b == ONES) ? '0 : obs_b))); // R4

endmodule

bind eac_prefix_adder eac_prefix_adder_chk #(.W(W), .REGISTERED(REGISTERED)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .op_a  (op_a),
    .op_b  (op_b),
    .sum   (sum)
);

// File: tb/tb_eac_prefix_adder.sv
`timescale 1ns/1ps
module tb_eac_prefix_adder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] in_a = '0;
    logic [15:0] in_b = '0;
    logic [3:0]  s4;
    logic [7:0]  s8;
    logic [11:0] s12;
    logic [15:0] s16;

    int checks = 0;
    int errors = 0;

    typedef struct {
        int     w;
        longint a;
        longint b;
        longint exp;
        string  tag;
    } item_t;

    item_t sb_q[$];

    always #4 clk = ~clk;   // 125 MHz

    eac_prefix_adder #(.W(8),  .REGISTERED(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .op_a(in_a[7:0]),  .op_b(in_b[7:0]),  .sum(s8));
    eac_prefix_adder #(.W(4),  .REGISTERED(1'b0)) dut4 (
        .clk(clk), .rst_n(rst_n), .op_a(in_a[3:0]),  .op_b(in_b[3:0]),  .sum(s4));
    eac_prefix_adder #(.W(12), .REGISTERED(1'b1)) dut12 (
        .clk(clk), .rst_n(rst_n), .op_a(in_a[11:0]), .op_b(in_b[11:0]), .sum(s12));
    eac_prefix_adder #(.W(16), .REGISTERED(1'b1)) dut16 (
        .clk(clk), .rst_n(rst_n), .op_a(in_a), .op_b(in_b), .sum(s16));

    function automatic longint expect_of(int w, longint a, longint b);
        longint m;
        m = (longint'(1) << w) - 1;
        return ((a % m) + (b % m)) % m;
    endfunction

    function automatic string tag_of(int w, longint a, longint b);
        longint ones;
        ones = (longint'(1) << w) - 1;
        if (a == ones || b == ones) return "R4";
        if (a + b == ones)          return "R3";
        if (a + b > ones)           return "R5";
        return "R1";
    endfunction

    function automatic longint out_of(int w);
        case (w)
            4:  return longint'(s4);
            8:  return longint'(s8);
            12: return longint'(s12);
            default: return longint'(s16);
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_item(input item_t it, input string extra);
        longint got, ones;
        got  = out_of(it.w);
        ones = (longint'(1) << it.w) - 1;
        check(got == it.exp, {it.tag, extra}, got, it.exp);
        check(got != ones, {"R2", extra}, got, it.exp);
    endtask

    // driver: apply operands at the falling edge, queue registered expectations
    task automatic drive(input logic [15:0] a, input logic [15:0] b);
        item_t it;
        @(negedge clk);
        in_a = a;
        in_b = b;
        foreach (it.tag[k]) ;
        it.w = 8;  it.a = a[7:0];  it.b = b[7:0];
        it.exp = expect_of(8, it.a, it.b);  it.tag = tag_of(8, it.a, it.b);  sb_q.push_back(it);
        it.w = 12; it.a = a[11:0]; it.b = b[11:0];
        it.exp = expect_of(12, it.a, it.b); it.tag = tag_of(12, it.a, it.b); sb_q.push_back(it);
        it.w = 16; it.a = a;       it.b = b;
        it.exp = expect_of(16, it.a, it.b); it.tag = tag_of(16, it.a, it.b); sb_q.push_back(it);
        // combinational copy: settles without a clock (R6)
        #1;
        it.w = 4; it.a = a[3:0]; it.b = b[3:0];
        it.exp = expect_of(4, it.a, it.b); it.tag = tag_of(4, it.a, it.b);
        check_item(it, " R6 comb");
    endtask

    // monitor: after each rising edge the registered results are compared
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                check_item(it, "");
            end
        end
    end

    initial begin
        #(8 * 300000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] prev16;
        in_a = 16'h1234;
        in_b = 16'h0F0F;
        repeat (3) @(negedge clk);
        // R7: registered outputs held at zero during reset
        check(s8 == 0,  "R7", s8, 0);
        check(s12 == 0, "R7", s12, 0);
        check(s16 == 0, "R7", s16, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R6: a new operand pair does not reach the register before the edge
        prev16 = s16;
        in_a = 16'h00FF;
        in_b = 16'h0101;
        #1;
        check(s16 == prev16, "R6 hold", s16, prev16);
        @(posedge clk);
        #2;
        check(s16 == expect_of(16, 16'h00FF, 16'h0101), "R6 latency", s16,
              expect_of(16, 16'h00FF, 16'h0101));

        // directed corners
        drive(16'hFFFF, 16'hFFFF);   // R4 both redundant zeros
        drive(16'hFFFF, 16'h0000);   // R4
        drive(16'h0000, 16'hFFFF);   // R4
        drive(16'hFFFF, 16'h3A5C);   // R4
        drive(16'h0000, 16'h0000);   // R1
        drive(16'h1234, 16'hEDCB);   // R3 complements
        drive(16'h5555, 16'hAAAA);   // R3
        drive(16'h8000, 16'h8000);   // R5 wrap
        drive(16'hFFFE, 16'h0002);   // R5
        drive(16'hFFFE, 16'hFFFE);   // R5
        drive(16'h7FFF, 16'h8000);   // R3

        // exhaustive for W=4 and W=8, random upper bits for W=12 and W=16
        for (int i = 0; i < 65536; i++) begin
            logic [7:0] ra, rb;
            ra = 8'($urandom);
            rb = 8'($urandom);
            drive({ra, 8'(i)}, {rb, 8'(i >> 8)});
        end

        @(posedge clk);
        #3;
        @(posedge clk);
        #3;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule